// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter Channel

This block is one timer/counter channel of a small 8-bit controller. The CPU clock is divided into machine cycles of six clock periods. The channel either counts machine cycles or counts falling edges seen on an external count pin. The count is held in two byte registers, a low byte and a high byte. A 2-bit mode field sets the counting width: a 13-bit count with a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads itself, or a held state. A run input, an optional gate qualifier, an overflow flag and an optional toggling output pin complete the channel.

The CPU side writes the count bytes through plain write strobes and reads them back on two byte outputs. These register accesses are single-cycle strobes with no valid/ready handshake: a write always lands on the clock edge where it is asserted, and nothing can apply back-pressure to it. The overflow flag stays set until a clear strobe arrives. When the toggle option is enabled, the toggle output inverts on every overflow. It can be routed to a pin as a square-wave source.

Top module: `tmr_channel`

## Requirements
- R1: After reset both count bytes read 0x00, and the overflow flag and toggle output are 0.
- R2: In timer function (`cnt_sel`=0) an enabled count advances once every 6 clock cycles. Machine-cycle boundaries fall on every sixth rising edge counted from reset release.
- R3: No count happens while `run`=0. No count happens while `gate_en`=1 and `gate_pin`=0. With `gate_en`=1 and `gate_pin`=1, counting proceeds as normal.
- R4: In counter function (`cnt_sel`=1) the count pin is sampled once per machine cycle. When one sample is 1 and the next is 0, the count advances at the boundary that ends the following machine cycle.
- R5: A low pulse on the count pin that starts and ends between two sample points is not counted.
- R6: In mode 0 (`mode`=0), bits 4:0 of the low byte form a prescaler that carries into the high byte. Bits 7:5 of the low byte keep their value. Overflow occurs when the high byte and the prescaler are all ones and advance.
- R7: In mode 1 (`mode`=1), {high,low} is a 16-bit count that overflows from 0xFFFF to 0x0000.
- R8: In mode 2 (`mode`=2) only the low byte counts. When it passes 0xFF it is loaded from the high byte, and the high byte does not change.
- R9: In mode 3 (`mode`=3) the count bytes hold their value. Only writes change them.
- R10: The overflow flag is set on the clock edge of an overflow and stays set until `clr_ovf` is asserted. If both happen on the same edge, the set wins.
- R11: With `toggle_en`=1, `tog_out` inverts on each overflow. With `toggle_en`=0 it keeps its level.
- R12: A byte write on a machine-cycle boundary takes priority. The written value is stored, and that boundary's advance is dropped for both bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable |
| gate_en | input | 1 | When 1, counting also needs `gate_pin` high |
| gate_pin | input | 1 | External gate level |
| cnt_sel | input | 1 | 0 = count machine cycles, 1 = count pin falling edges |
| mode | input | 2 | Width mode (0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = hold) |
| toggle_en | input | 1 | Enables the toggle output on overflow |
| ext_pin | input | 1 | External count pin |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Write data |
| clr_ovf | input | 1 | Clears the overflow flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| tog_out | output | 1 | Output that toggles on overflow |

## Verification
The hardest situations to reach from the ports depend on the hidden machine-cycle phase. One is a count-pin pulse that falls entirely between two sample points. The other is a byte write that lands exactly on a boundary edge. The bench keeps its own phase counter, started at reset release, and waits for a chosen phase before driving such stimulus. It drops the pin for two clocks right after a sample point, and it pulses a write on the clock just before a boundary. Overflow in each mode is reached quickly by preloading near-full counts through the write strobes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13   = 2'd0,
    MD_16   = 2'd1,
    MD_8RL  = 2'd2,
    MD_HOLD = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_phase.sv
// Machine-cycle divider: one tick pulse every DIV clocks.
module tmr_phase #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tmr_edge.sv
// Samples the count pin once per machine cycle; flags a high-then-low pair.
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= 1'b0;
      fall <= 1'b0;
    end else if (tick) begin
      smp  <= pin;
      fall <= smp & ~pin;
    end
  end
endmodule

// File: rtl/tmr_core.sv
// Count registers, mode-dependent advance, overflow flag and toggle output.
module tmr_core
  import tmr_pkg::*;
#(
  parameter int BW  = 8,
  parameter int PRE = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          inc_en,
  input  tmr_mode_e     mode,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  input  logic          clr_ovf,
  input  logic          toggle_en,
  output logic [BW-1:0] cnt_lo,
  output logic [BW-1:0] cnt_hi,
  output logic          ovf_flag,
  output logic          tog_out,
  output logic          ovf_pulse
);
  localparam int CW = 2 * BW;
  localparam logic [CW-1:0] ONE_W = CW'(1);

  logic [BW-1:0] nxt_lo, nxt_hi;
  logic          wrap, step;

  always_comb begin
    nxt_lo = cnt_lo;
    nxt_hi = cnt_hi;
    wrap   = 1'b0;
    unique case (mode)
      MD_13: begin
        if (&cnt_lo[PRE-1:0]) begin
          nxt_lo[PRE-1:0] = '0;
          nxt_hi          = cnt_hi + 1'b1;
          wrap            = &cnt_hi;
        end else begin
          nxt_lo[PRE-1:0] = cnt_lo[PRE-1:0] + 1'b1;
        end
      end
      MD_16: begin
        {nxt_hi, nxt_lo} = {cnt_hi, cnt_lo} + ONE_W;
        wrap             = &{cnt_hi, cnt_lo};
      end
      MD_8RL: begin
        if (&cnt_lo) begin
          nxt_lo = cnt_hi;
          wrap   = 1'b1;
        end else begin
          nxt_lo = cnt_lo + 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign step      = tick & inc_en & ~(wr_lo | wr_hi) & (mode != MD_HOLD);
  assign ovf_pulse = step & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo   <= '0;
      cnt_hi   <= '0;
      ovf_flag <= 1'b0;
      tog_out  <= 1'b0;
    end else begin
      if (wr_lo)     cnt_lo <= wr_data;
      else if (step) cnt_lo <= nxt_lo;
      if (wr_hi)     cnt_hi <= wr_data;
      else if (step) cnt_hi <= nxt_hi;
      if (ovf_pulse)    ovf_flag <= 1'b1;
      else if (clr_ovf) ovf_flag <= 1'b0;
      if (ovf_pulse && toggle_en) tog_out <= ~tog_out;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DIV = 6,
  parameter int BW  = 8,
  parameter int PRE = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          gate_en,
  input  logic          gate_pin,
  input  logic          cnt_sel,
  input  logic [1:0]    mode,
  input  logic          toggle_en,
  input  logic          ext_pin,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wr_data,
  input  logic          clr_ovf,
  output logic [BW-1:0] cnt_lo,
  output logic [BW-1:0] cnt_hi,
  output logic          ovf_flag,
  output logic          tog_out
);
  logic mc_tick, pin_fall, inc_en, ovf_pulse;

  tmr_phase #(.DIV(DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick)
  );

  tmr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .pin(ext_pin), .fall(pin_fall)
  );

  assign inc_en = run & (~gate_en | gate_pin) & (cnt_sel ? pin_fall : 1'b1);

  tmr_core #(.BW(BW), .PRE(PRE)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .inc_en(inc_en),
    .mode(tmr_mode_e'(mode)), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .clr_ovf(clr_ovf), .toggle_en(toggle_en), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ovf_flag(ovf_flag), .tog_out(tog_out), .ovf_pulse(ovf_pulse)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int DIV = 6,
  parameter int BW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [1:0]    mode,
  input logic          toggle_en,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic [BW-1:0] wr_data,
  input logic          clr_ovf,
  input logic [BW-1:0] cnt_lo,
  input logic [BW-1:0] cnt_hi,
  input logic          ovf_flag,
  input logic          tog_out,
  input logic          tick,
  input logic          ovf_pulse
);
  localparam int GW = $clog2(DIV) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap <= '0;
    else if (tick) gap <= '0;
    else           gap <= gap + 1'b1;
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap == GW'(DIV - 1)));

  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_reload_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_hi) |=> $stable(cnt_hi));

  p_hold_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> ovf_flag);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !ovf_pulse) |=> !ovf_flag);

  p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && toggle_en) |=> (tog_out != $past(tog_out)));

  p_no_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_pulse && toggle_en) |=> $stable(tog_out));

  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data)));
endmodule

bind tmr_channel tmr_channel_chk #(.DIV(DIV), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .toggle_en(toggle_en),
  .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .clr_ovf(clr_ovf),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .tog_out(tog_out),
  .tick(mc_tick), .ovf_pulse(ovf_pulse)
);

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, gate_en = 0, gate_pin = 0, cnt_sel = 0, toggle_en = 0;
  logic ext_pin = 0, wr_lo = 0, wr_hi = 0, clr_ovf = 0;
  logic [1:0] mode = 2'd1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf_flag, tog_out;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  // reference model state
  int m_ph, m_lo, m_hi, m_ovf, m_tog, m_smp, m_pend;

  always #10 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .run(run), .gate_en(gate_en), .gate_pin(gate_pin),
    .cnt_sel(cnt_sel), .mode(mode), .toggle_en(toggle_en), .ext_pin(ext_pin),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .clr_ovf(clr_ovf),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .tog_out(tog_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_lo = 0; m_hi = 0; m_ovf = 0; m_tog = 0; m_smp = 0; m_pend = 0;
    end else begin
      bit used, en, ov;
      ov = 0;
      if (m_ph == 5) begin
        used   = (m_pend != 0);
        m_pend = (m_smp == 1 && ext_pin == 0) ? 1 : 0;
        m_smp  = ext_pin ? 1 : 0;
        en = run && (!gate_en || gate_pin) && (cnt_sel ? used : 1'b1)
             && mode != 2'd3 && !wr_lo && !wr_hi;
        if (en) begin
          case (mode)
            2'd0: begin
              if ((m_lo & 31) == 31) begin
                m_lo = m_lo & 8'hE0;
                if (m_hi == 255) begin m_hi = 0; ov = 1; end else m_hi = m_hi + 1;
              end else m_lo = m_lo + 1;
            end
            2'd1: begin
              int v;
              v = m_hi * 256 + m_lo + 1;
              if (v == 65536) begin v = 0; ov = 1; end
              m_hi = v / 256; m_lo = v % 256;
            end
            default: begin
              if (m_lo == 255) begin m_lo = m_hi; ov = 1; end else m_lo = m_lo + 1;
            end
          endcase
        end
      end
      if (wr_lo) m_lo = wr_data;
      if (wr_hi) m_hi = wr_data;
      if (ov) m_ovf = 1; else if (clr_ovf) m_ovf = 0;
      if (ov && toggle_en) m_tog = 1 - m_tog;
      m_ph = (m_ph + 1) % 6;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (cnt_lo != m_lo[7:0] || cnt_hi != m_hi[7:0] || ovf_flag != m_ovf[0] ||
          tog_out != m_tog[0]) begin
        errors++;
        $display("FAIL %s: lo=%02h hi=%02h ovf=%0d tog=%0d expected lo=%02h hi=%02h ovf=%0d tog=%0d",
                 tag, cnt_lo, cnt_hi, ovf_flag, tog_out, m_lo, m_hi, m_ovf, m_tog);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_val(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic load(input int hi, input int lo);
    @(negedge clk);
    wr_hi = 1; wr_lo = 0; wr_data = hi[7:0];
    @(negedge clk);
    wr_hi = 0; wr_lo = 1; wr_data = lo[7:0];
    @(negedge clk);
    wr_lo = 0;
  endtask

  task automatic wait_phase(input int p);
    while (m_ph != p) @(negedge clk);
  endtask

  initial begin
    int snap;
    wait_cyc(3);
    check_val("R1 lo", cnt_lo, 0);
    check_val("R1 hi", cnt_hi, 0);
    check_val("R1 ovf", ovf_flag, 0);
    check_val("R1 tog", tog_out, 0);
    rst_n = 1;

    tag = "R2"; run = 1; mode = 2'd1;
    wait_cyc(60);
    check_val("R2 count after 60 clocks", cnt_lo, 10);

    tag = "R3"; run = 0; snap = cnt_lo;
    wait_cyc(30);
    check_val("R3 run low holds", cnt_lo, snap);
    run = 1; gate_en = 1; gate_pin = 0;
    wait_cyc(30);
    check_val("R3 gate low holds", cnt_lo, snap);
    gate_pin = 1;
    wait_cyc(30);
    gate_en = 0;

    tag = "R7"; toggle_en = 1;
    load(8'hFF, 8'hF0);
    wait_cyc(120);
    check_val("R7 wrapped hi", cnt_hi, 0);
    check_val("R10 flag set", ovf_flag, 1);
    check_val("R11 toggled", tog_out, 1);
    tag = "R10";
    wait_cyc(20);
    check_val("R10 flag sticky", ovf_flag, 1);
    @(negedge clk); clr_ovf = 1; @(negedge clk); clr_ovf = 0;
    check_val("R10 flag cleared", ovf_flag, 0);

    tag = "R11"; toggle_en = 0;
    load(8'hFF, 8'hFE);
    wait_cyc(30);
    check_val("R11 no toggle when disabled", tog_out, 1);
    toggle_en = 1;

    tag = "R6"; mode = 2'd0;
    load(8'hFF, 8'hFC);
    wait_cyc(40);
    check_val("R6 upper low bits kept", cnt_lo[7:5], 3'b111);
    check_val("R6 hi wrapped", cnt_hi, 0);
    wait_cyc(200);

    tag = "R8"; mode = 2'd2;
    load(8'hF0, 8'hFA);
    wait_cyc(60);
    check_val("R8 hi unchanged", cnt_hi, 8'hF0);
    check_val("R8 reloaded range", (cnt_lo >= 8'hF0) ? 1 : 0, 1);
    wait_cyc(100);

    tag = "R9"; mode = 2'd3; snap = {cnt_hi, cnt_lo};
    wait_cyc(40);
    check_val("R9 hold mode", {cnt_hi, cnt_lo}, snap);

    tag = "R4"; mode = 2'd1; cnt_sel = 1; ext_pin = 1;
    load(8'h00, 8'h00);
    wait_cyc(12);
    for (int k = 0; k < 5; k++) begin
      ext_pin = 0; wait_cyc(12);
      ext_pin = 1; wait_cyc(12);
    end
    wait_cyc(12);
    check_val("R4 five falling edges counted", cnt_lo, 5);

    tag = "R5"; snap = cnt_lo;
    wait_phase(1);
    ext_pin = 0; wait_cyc(2); ext_pin = 1;
    wait_cyc(30);
    check_val("R5 short pulse ignored", cnt_lo, snap);

    tag = "R12"; cnt_sel = 0;
    wait_cyc(7);
    wait_phase(5);
    wr_lo = 1; wr_data = 8'h55;
    @(negedge clk); wr_lo = 0;
    check_val("R12 write wins at boundary lo", cnt_lo, 8'h55);
    wait_cyc(3);
    check_val("R12 no advance same boundary", cnt_lo, 8'h55);
    wait_cyc(6);
    check_val("R12 advance resumes", cnt_lo, 8'h56);

    wait_cyc(5);
    finish_run();
  end
endmodule